// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page Protection and Superpages

This block caches recent virtual-to-physical page translations in a small, fully associative table. A requester presents a virtual address with an access type (read or write) and a privilege level (user or supervisor). One cycle later the block answers with exactly one of three results: a hit with the translated physical address, a miss, or a protection fault. The page offset passes through unchanged. Only the page number is translated.

Each entry maps either one base page or an aligned group of 2^SP_BITS base pages, which is a superpage. For a superpage entry, the low SP_BITS of the virtual page number are left out of the tag compare and are copied straight into the physical address. Every entry also carries read, write and user-access permission bits, and these are checked against every access that matches.

A miss starts a refill through a request/acknowledge port that faces an external page walker. The returned translation goes into the lowest-numbered free slot. When no slot is free, a round-robin pointer chooses the victim. A flush input invalidates the whole table in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `walk_req` are low and every entry is invalid, so the first lookup misses.
- R2: A lookup presented with `lk_valid` gets its result registered on the next cycle. When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high.
- R3: A hit on a base-page entry returns `rsp_paddr = {ppn, vaddr[11:0]}`.
- R4: A superpage entry matches when VPN bits [11:4] equal its tag. It returns `{ppn[11:4], vaddr[15:12], vaddr[11:0]}`, so the low 4 bits of the stored PPN have no effect.
- R5: A matching access produces a fault, not a hit, in any of these cases: a write to an entry whose write bit is 0, a read from an entry whose read bit is 0, or a user access (`lk_user`=1) to an entry whose user bit is 0. `rsp_paddr` is zero unless `rsp_hit` is high.
- R6: A miss raises `walk_req` one cycle after the lookup, with `walk_vpn` set to the missing VPN. Both hold until a cycle in which `walk_ack` is high. On that edge the returned PPN, permissions and superpage flag are installed, and `walk_req` falls.
- R7: While a walk is outstanding, further misses are still reported. They do not change `walk_vpn` and do not raise a second request.
- R8: A refill fills the lowest-numbered invalid entry while one exists, so filling N distinct pages into an empty table evicts nothing.
- R9: With every entry valid, refills replace entries in round-robin order starting at entry 0. The pointer advances by one on each such replacement.
- R10: `flush` invalidates all entries at the next edge, so a lookup in the following cycle misses. A refill acknowledged in the same cycle as `flush` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 24 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Result valid, one cycle after lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry denies the access |
| rsp_paddr | output | 24 | Physical address on hit, else zero |
| walk_req | output | 1 | Refill request to page walker |
| walk_vpn | output | 12 | VPN to be walked |
| walk_ack | input | 1 | Walker returns translation this cycle |
| walk_ppn | input | 12 | Returned physical page number |
| walk_rd | input | 1 | Returned read permission |
| walk_wr | input | 1 | Returned write permission |
| walk_usr | input | 1 | Returned user-access permission |
| walk_super | input | 1 | Returned entry is a superpage |

## Verification
The bench checks superpage lookups at both ends of a 16-page group and just past it. It uses a stored PPN with nonzero low bits, so a design that compares or substitutes the low VPN bits either misses or returns the wrong frame. Each permission bit is denied separately. A checker that ignores one of them returns a hit where a fault is due, and a design that sends a hit's address on a fault leaks a nonzero `rsp_paddr`. The bench issues a second miss while a walk is pending, so a design that restarts the walk shows a changed `walk_vpn`. It acknowledges a refill in the same cycle as a flush, so a design that lets the fill win shows a stray hit. Finally it overfills the table twice in a row, so a pointer that does not advance, or that evicts from a fixed slot, keeps the wrong entries resident.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  // Per-entry access permissions
  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } perm_t;

  // Result kind of a lookup
  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_HIT   = 2'd1,
    RES_FAULT = 2'd2
  } res_e;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 12,
  parameter int PPN_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic               wr_super,
  output logic [ENTRIES-1:0] valid_o,
  output logic [VPN_W-1:0]   vpn_o   [ENTRIES],
  output logic [PPN_W-1:0]   ppn_o   [ENTRIES],
  output perm_t              perm_o  [ENTRIES],
  output logic [ENTRIES-1:0] super_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    logic valid_d;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      valid_d = valid_o[g];
      if (flush)    valid_d = 1'b0;
      else if (sel) valid_d = 1'b1;
    end

    // Valid bit: reset to empty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o[g] <= 1'b0;
      else        valid_o[g] <= valid_d;
    end

    // Payload: written only on fill, no reset needed
    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_o[g]   <= wr_vpn;
        ppn_o[g]   <= wr_ppn;
        perm_o[g]  <= wr_perm;
        super_o[g] <= wr_super;
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 12,
  parameter int PPN_W   = 12,
  parameter int SP_BITS = 4
) (
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   vpn_i   [ENTRIES],
  input  logic [PPN_W-1:0]   ppn_i   [ENTRIES],
  input  perm_t              perm_i  [ENTRIES],
  input  logic [ENTRIES-1:0] super_i,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  output perm_t              hit_perm,
  output logic               hit_super
);

  localparam int HI_W = VPN_W - SP_BITS;

  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic hi_eq;
    logic lo_eq;
    assign hi_eq = vpn[VPN_W-1:SP_BITS] == vpn_i[g][VPN_W-1:SP_BITS];
    assign lo_eq = vpn[SP_BITS-1:0] == vpn_i[g][SP_BITS-1:0];
    assign eq[g] = valid_i[g] && hi_eq && (super_i[g] || lo_eq);
  end

  // Lowest matching index wins
  always_comb begin
    hit       = 1'b0;
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_super = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit       = 1'b1;
        hit_ppn   = ppn_i[i];
        hit_perm  = perm_i[i];
        hit_super = super_i[i];
      end
    end
  end

  if (HI_W < 1) begin : g_bad
    initial $error("SP_BITS must be smaller than VPN_W");
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               alloc,
  output logic [IDX_W-1:0]   idx
);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_d;
  logic             rr_en;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign idx   = free_found ? free_idx : rr_q;
  assign rr_en = alloc && !free_found;

  always_comb begin
    if (rr_q == IDX_W'(ENTRIES - 1)) rr_d = '0;
    else                             rr_d = rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W    = 24,
  parameter int OFS_W   = 12,
  parameter int PPN_W   = 12,
  parameter int ENTRIES = 16,
  parameter int SP_BITS = 4,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PA_W   = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_ack,
  input  logic [PPN_W-1:0] walk_ppn,
  input  logic             walk_rd,
  input  logic             walk_wr,
  input  logic             walk_usr,
  input  logic             walk_super
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFS_W-1:0]   lk_ofs;
  logic [ENTRIES-1:0] e_valid;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  perm_t              e_perm [ENTRIES];
  logic [ENTRIES-1:0] e_super;
  logic               m_hit;
  logic [PPN_W-1:0]   m_ppn;
  perm_t              m_perm;
  logic               m_super;
  logic               deny;
  res_e               res_c;
  logic [PA_W-1:0]    paddr_c;
  logic               fill;
  logic               fill_en;
  logic [IDX_W-1:0]   fill_idx;
  perm_t              fill_perm;

  // Next-state signals
  logic               rsp_valid_d;
  logic               rsp_hit_d;
  logic               rsp_miss_d;
  logic               rsp_fault_d;
  logic [PA_W-1:0]    rsp_paddr_d;
  logic               walk_req_d;
  logic               walk_issue;

  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
  assign lk_ofs = lk_vaddr[OFS_W-1:0];

  tlb_entry_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_vpn   (walk_vpn),
    .wr_ppn   (walk_ppn),
    .wr_perm  (fill_perm),
    .wr_super (walk_super),
    .valid_o  (e_valid),
    .vpn_o    (e_vpn),
    .ppn_o    (e_ppn),
    .perm_o   (e_perm),
    .super_o  (e_super)
  );

  tlb_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .SP_BITS (SP_BITS)
  ) u_match (
    .vpn       (lk_vpn),
    .valid_i   (e_valid),
    .vpn_i     (e_vpn),
    .ppn_i     (e_ppn),
    .perm_i    (e_perm),
    .super_i   (e_super),
    .hit       (m_hit),
    .hit_ppn   (m_ppn),
    .hit_perm  (m_perm),
    .hit_super (m_super)
  );

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (e_valid),
    .alloc   (fill_en),
    .idx     (fill_idx)
  );

  // Refill control
  assign fill      = walk_req && walk_ack;
  assign fill_en   = fill && !flush;
  assign fill_perm = '{rd: walk_rd, wr: walk_wr, usr: walk_usr};

  // Permission check and address formation
  always_comb begin
    deny = (lk_write && !m_perm.wr) || (!lk_write && !m_perm.rd) ||
           (lk_user && !m_perm.usr);
    if (!m_hit)    res_c = RES_MISS;
    else if (deny) res_c = RES_FAULT;
    else           res_c = RES_HIT;

    if (m_super) paddr_c = {m_ppn[PPN_W-1:SP_BITS], lk_vpn[SP_BITS-1:0], lk_ofs};
    else         paddr_c = {m_ppn, lk_ofs};
  end

  // Next-state logic
  always_comb begin
    rsp_valid_d = lk_valid;
    rsp_hit_d   = lk_valid && (res_c == RES_HIT);
    rsp_miss_d  = lk_valid && (res_c == RES_MISS);
    rsp_fault_d = lk_valid && (res_c == RES_FAULT);
    rsp_paddr_d = rsp_hit_d ? paddr_c : '0;

    walk_issue = !walk_req && lk_valid && (res_c == RES_MISS);
    walk_req_d = walk_req;
    if (fill)            walk_req_d = 1'b0;
    else if (walk_issue) walk_req_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      walk_req  <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_miss  <= rsp_miss_d;
      rsp_fault <= rsp_fault_d;
      rsp_paddr <= rsp_paddr_d;
      walk_req  <= walk_req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          walk_vpn <= '0;
    else if (walk_issue) walk_vpn <= lk_vpn;
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int OFS_W = 12,
  parameter int PA_W  = 24,
  parameter int VPN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [OFS_W-1:0] lk_ofs,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             walk_ack
);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R2

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFS_W-1:0] == $past(lk_ofs)); // R3

  AST_PADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0); // R5

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_ack) |=> !walk_req); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_valid |=> rsp_miss); // R10

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .OFS_W (OFS_W),
  .PA_W  (PA_W),
  .VPN_W (VPN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .lk_valid  (lk_valid),
  .lk_ofs    (lk_vaddr[OFS_W-1:0]),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .walk_req  (walk_req),
  .walk_vpn  (walk_vpn),
  .walk_ack  (walk_ack)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int K_HIT      = 1;
  localparam int K_MISS     = 0;
  localparam int K_FAULT    = 2;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        lk_valid;
  logic [23:0] lk_vaddr;
  logic        lk_write;
  logic        lk_user;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_miss;
  logic        rsp_fault;
  logic [23:0] rsp_paddr;
  logic        walk_req;
  logic [11:0] walk_vpn;
  logic        walk_ack;
  logic [11:0] walk_ppn;
  logic        walk_rd;
  logic        walk_wr;
  logic        walk_usr;
  logic        walk_super;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int          qk [$];
  logic [23:0] qp [$];
  string       qt [$];

  tlb_xlate #(.ENTRIES(ENTRIES)) i_tlb_xlate (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_write   (lk_write),
    .lk_user    (lk_user),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .walk_ack   (walk_ack),
    .walk_ppn   (walk_ppn),
    .walk_rd    (walk_rd),
    .walk_wr    (walk_wr),
    .walk_usr   (walk_usr),
    .walk_super (walk_super)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: present one lookup and push its expected result
  task automatic lookup(input logic [23:0] va, input bit wr, input bit usr,
                        input int kind, input logic [23:0] pa, input string tag);
    @(negedge clk);
    qk.push_back(kind);
    qp.push_back(kind == K_HIT ? pa : 24'h0);
    qt.push_back(tag);
    lk_valid = 1'b1;
    lk_vaddr = va;
    lk_write = wr;
    lk_user  = usr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // Monitor: pop and compare each result as it appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      if (qk.size() == 0) begin
        check(1'b0, "R2", "unexpected result", 32'(rsp_valid), 32'h0);
      end else begin
        int          k;
        logic [23:0] p;
        string       t;
        int          got;
        k = qk.pop_front();
        p = qp.pop_front();
        t = qt.pop_front();
        got = rsp_hit ? K_HIT : (rsp_fault ? K_FAULT : K_MISS);
        check(got == k && $countones({rsp_hit, rsp_miss, rsp_fault}) == 1,
              t, "result kind", 32'(got), 32'(k));
        check(rsp_paddr == p, t, "paddr", 32'(rsp_paddr), 32'(p));
      end
    end
  end

  // Page walker model: answer the outstanding request
  task automatic serve(input logic [11:0] vpn, input logic [11:0] ppn,
                       input bit r, input bit w, input bit u, input bit sp,
                       input bit with_flush);
    int n = 0;
    while (!walk_req && n < 8) begin
      @(negedge clk);
      n++;
    end
    check(walk_req == 1'b1, "R6", "walk_req raised", 32'(walk_req), 32'h1);
    check(walk_vpn == vpn, "R6", "walk_vpn", 32'(walk_vpn), 32'(vpn));
    walk_ack   = 1'b1;
    walk_ppn   = ppn;
    walk_rd    = r;
    walk_wr    = w;
    walk_usr   = u;
    walk_super = sp;
    flush      = with_flush;
    @(negedge clk);
    walk_ack = 1'b0;
    flush    = 1'b0;
    check(walk_req == 1'b0, "R6", "walk_req dropped", 32'(walk_req), 32'h0);
  endtask

  task automatic install(input logic [11:0] vpn, input logic [11:0] ppn,
                         input bit r, input bit w, input bit u, input bit sp);
    lookup({vpn, 12'h000}, 1'b0, 1'b0, K_MISS, 24'h0, "R6");
    serve(vpn, ppn, r, w, u, sp, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
    lk_write = 1'b0; lk_user = 1'b0; walk_ack = 1'b0; walk_ppn = '0;
    walk_rd = 1'b0; walk_wr = 1'b0; walk_usr = 1'b0; walk_super = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check(walk_req == 1'b0, "R1", "walk_req in reset", 32'(walk_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table misses; R3: base-page translation
    lookup(24'h123456, 1'b0, 1'b1, K_MISS, 24'h0, "R1");
    serve(12'h123, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(24'h123456, 1'b0, 1'b1, K_HIT, 24'hABC456, "R3");
    lookup(24'h123FFF, 1'b1, 1'b1, K_HIT, 24'hABCFFF, "R3");

    // R5: read-only supervisor page
    install(12'h200, 12'h055, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(24'h200010, 1'b1, 1'b0, K_FAULT, 24'h0, "R5");
    lookup(24'h200010, 1'b0, 1'b1, K_FAULT, 24'h0, "R5");
    lookup(24'h200010, 1'b0, 1'b0, K_HIT, 24'h055010, "R5");

    // R5: write-only user page
    install(12'h300, 12'h066, 1'b0, 1'b1, 1'b1, 1'b0);
    lookup(24'h300ABC, 1'b0, 1'b1, K_FAULT, 24'h0, "R5");
    lookup(24'h300ABC, 1'b1, 1'b1, K_HIT, 24'h066ABC, "R5");

    // R4: superpage covering VPN 0x140..0x14F, stored PPN low bits nonzero
    install(12'h14A, 12'h7A5, 1'b1, 1'b1, 1'b1, 1'b1);
    lookup(24'h14F123, 1'b0, 1'b0, K_HIT, 24'h7AF123, "R4");
    lookup(24'h140000, 1'b1, 1'b1, K_HIT, 24'h7A0000, "R4");
    lookup(24'h150000, 1'b0, 1'b0, K_MISS, 24'h0, "R4");

    // R7: second miss while the walk for 0x150 is pending
    lookup(24'h160000, 1'b0, 1'b0, K_MISS, 24'h0, "R7");
    check(walk_req == 1'b1 && walk_vpn == 12'h150, "R7", "pending vpn kept",
          32'(walk_vpn), 32'h150);
    serve(12'h150, 12'h111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(24'h150004, 1'b0, 1'b0, K_HIT, 24'h111004, "R6");
    install(12'h160, 12'h222, 1'b1, 1'b1, 1'b1, 1'b0);

    // R10: flush, then flush racing a refill
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lookup(24'h123456, 1'b0, 1'b0, K_MISS, 24'h0, "R10");
    serve(12'h123, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    lookup(24'h123456, 1'b0, 1'b0, K_MISS, 24'h0, "R10");
    serve(12'h123, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(24'h123456, 1'b0, 1'b0, K_HIT, 24'hABC456, "R10");

    // R8: fill an empty table completely, nothing evicted
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      install(12'h400 + 12'(i), 12'h800 + 12'(i), 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < ENTRIES; i++)
      lookup({12'h400 + 12'(i), 12'h00C}, 1'b0, 1'b0, K_HIT,
             {12'h800 + 12'(i), 12'h00C}, "R8");

    // R9: round-robin eviction starting at entry 0
    install(12'h410, 12'h900, 1'b1, 1'b1, 1'b1, 1'b0);
    lookup(24'h401000, 1'b0, 1'b0, K_HIT, 24'h801000, "R9");
    lookup(24'h410000, 1'b0, 1'b0, K_HIT, 24'h900000, "R9");
    lookup(24'h400000, 1'b0, 1'b0, K_MISS, 24'h0, "R9");
    serve(12'h400, 12'h800, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(24'h401000, 1'b0, 1'b0, K_MISS, 24'h0, "R9");
    serve(12'h401, 12'h801, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(24'h403000, 1'b0, 1'b0, K_HIT, 24'h803000, "R9");
    lookup(24'h402000, 1'b0, 1'b0, K_MISS, 24'h0, "R9");
    lookup(24'h410000, 1'b0, 1'b0, K_HIT, 24'h900000, "R9");
    serve(12'h402, 12'h802, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    check(qk.size() == 0, "R2", "results outstanding", 32'(qk.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule